// File: doc/BRIEF.md
# Two-Level ALU Control and 32-bit ALU

This block is the arithmetic stage of a simple single-issue datapath. The main instruction decoder supplies a 2-bit class code, and the instruction supplies its 6-bit function field. A small second-level decoder maps these two inputs to a 4-bit control word, and a 32-bit ALU then acts on two operands under that word. The main decoder therefore only has to name a class: memory access, compare-for-branch, or register arithmetic. It does not need to know individual arithmetic functions.

The control word has an invert-first-operand bit, an invert-second-operand bit and a 2-bit operation select (AND, OR, sum, less-than). Every supported function is one of these four basic operations applied to possibly inverted operands. Subtraction is a sum with the second operand inverted and a carry-in of one. NOR is an AND of both inverted operands. The ALU returns the 32-bit result, a zero flag for equality branches and a signed overflow flag. The control word is also driven out, so the neighbouring logic and the bench can observe the decoded operation.

Top module: `alu_two_level`

## Requirements
- R1: With class code 00 the control word is 0010 (add), for every function field value.
- R2: With class code 01 the control word is 0110 (subtract), for every function field value.
- R3: With class code 10 or 11, function bits 3..0 select the operation and bits 5..4 are ignored: 0000 gives 0010 (add), 0010 gives 0110 (subtract), 0100 gives 0000 (AND), 0101 gives 0001 (OR), 0111 gives 1100 (NOR), 1010 gives 0111 (less-than).
- R4: With class code 10 or 11, any other function bits 3..0 give 0010 (add).
- R5: Control word bit 3 inverts operand A and bit 2 inverts operand B. Bits 1..0 select the operation: 00 AND, 01 OR, 10 sum, 11 less-than. Less-than always has bit 2 set.
- R6: Words 0000, 0001 and 1100 produce A AND B, A OR B and NOT(A OR B) respectively.
- R7: Word 0010 produces A+B and word 0110 produces A-B, both modulo 2^32.
- R8: Word 0111 produces 1 when A is less than B as signed 32-bit numbers, and 0 otherwise. Bits 31..1 of the result are always 0. The result is correct even when A-B overflows.
- R9: The zero output is 1 exactly when all 32 result bits are 0.
- R10: The overflow output is 1 only for add and subtract, when the signed result does not fit in 32 bits. It is 0 for AND, OR, NOR and less-than.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| alu_op | input | 2 | Class code from the main decoder |
| funct | input | 6 | Function field of the instruction |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| ctrl_word | output | 4 | Decoded control word {invert A, invert B, select} |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The block is purely combinational, so a wrong internal value appears at the ports in the same cycle as the input that exposes it. A decode error appears directly on ctrl_word. A wrong invert bit or carry-in changes the result by one, or flips every bit of it, and this usually also moves zero. A missing overflow correction in the less-than path gives the wrong answer only when the operands have opposite signs and large magnitudes, so the bench includes the extreme values in its operand sweeps.

// File: rtl/alu2l_pkg.sv
package alu2l_pkg;

  localparam int CLASS_W = 2;
  localparam int CTRL_W  = 4;

  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } opsel_e;

  typedef struct packed {
    logic   inv_a;
    logic   inv_b;
    opsel_e sel;
  } alu_ctrl_t;

  localparam alu_ctrl_t CW_AND  = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_AND};
  localparam alu_ctrl_t CW_OR   = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_OR};
  localparam alu_ctrl_t CW_ADD  = '{inv_a: 1'b0, inv_b: 1'b0, sel: SEL_SUM};
  localparam alu_ctrl_t CW_SUB  = '{inv_a: 1'b0, inv_b: 1'b1, sel: SEL_SUM};
  localparam alu_ctrl_t CW_LESS = '{inv_a: 1'b0, inv_b: 1'b1, sel: SEL_LESS};
  localparam alu_ctrl_t CW_NOR  = '{inv_a: 1'b1, inv_b: 1'b1, sel: SEL_AND};

endpackage

// File: rtl/alu2l_ctrl_dec.sv
module alu2l_ctrl_dec
  import alu2l_pkg::*;
#(
  parameter int FUNCT_W = 6
) (
  input  logic [CLASS_W-1:0] alu_op,
  input  logic [FUNCT_W-1:0] funct,
  output alu_ctrl_t          ctrl
);

  // Only the low bits of the function field are decoded; the top two are fixed.
  localparam int SEL_W = FUNCT_W - 2;

  logic [SEL_W-1:0] fsel;
  assign fsel = funct[SEL_W-1:0];

  always_comb begin
    if (!alu_op[1]) begin
      ctrl = alu_op[0] ? CW_SUB : CW_ADD;
    end else begin
      case (fsel)
        SEL_W'(4'b0000): ctrl = CW_ADD;
        SEL_W'(4'b0010): ctrl = CW_SUB;
        SEL_W'(4'b0100): ctrl = CW_AND;
        SEL_W'(4'b0101): ctrl = CW_OR;
        SEL_W'(4'b0111): ctrl = CW_NOR;
        SEL_W'(4'b1010): ctrl = CW_LESS;
        default:         ctrl = CW_ADD;
      endcase
    end
  end

  // Assertions: class-code rows of the decode table
  always_comb begin
    if (alu_op == 2'b00)
      assert_class_add_R1: assert (ctrl == CW_ADD);
    if (alu_op == 2'b01)
      assert_class_sub_R2: assert (ctrl == CW_SUB);
    if (ctrl.sel == SEL_LESS)
      assert_less_invb_R5: assert (ctrl.inv_b && !ctrl.inv_a);
  end

endmodule

// File: rtl/alu2l_core.sv
module alu2l_core
  import alu2l_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow
);

  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH-1:0] add_cin(input logic [WIDTH-1:0] x,
                                               input logic [WIDTH-1:0] y,
                                               input logic cin);
    return x + y + {{(WIDTH-1){1'b0}}, cin};
  endfunction

  function automatic logic sign_ovf(input logic [WIDTH-1:0] x,
                                    input logic [WIDTH-1:0] y,
                                    input logic [WIDTH-1:0] s);
    return (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]);
  endfunction

  logic [WIDTH-1:0] opnd_a, opnd_b, sum;
  logic             sum_ovf;   // raw adder overflow, any selection
  logic             less_bit;  // corrected signed sign of the difference

  assign opnd_a   = ctrl.inv_a ? ~a : a;
  assign opnd_b   = ctrl.inv_b ? ~b : b;
  assign sum      = add_cin(opnd_a, opnd_b, ctrl.inv_b);
  assign sum_ovf  = sign_ovf(opnd_a, opnd_b, sum);
  assign less_bit = sum[MSB] ^ sum_ovf;

  always_comb begin
    case (ctrl.sel)
      SEL_AND:  result = opnd_a & opnd_b;
      SEL_OR:   result = opnd_a | opnd_b;
      SEL_SUM:  result = sum;
      default:  result = {{(WIDTH-1){1'b0}}, less_bit};
    endcase
  end

  assign overflow = (ctrl.sel == SEL_SUM) && sum_ovf;
  assign zero     = ~|result;

  always_comb begin
    if (ctrl.sel == SEL_LESS)
      assert_less_upper_R8: assert (result[MSB:1] == '0);
    if (ctrl.sel != SEL_SUM)
      assert_no_overflow_R10: assert (!overflow);
  end

endmodule

// File: rtl/alu_two_level.sv
module alu_two_level
  import alu2l_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int FUNCT_W = 6
) (
  input  logic [1:0]         alu_op,
  input  logic [FUNCT_W-1:0] funct,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic [3:0]         ctrl_word,
  output logic [WIDTH-1:0]   result,
  output logic               zero,
  output logic               overflow
);

  alu_ctrl_t ctrl;

  alu2l_ctrl_dec #(.FUNCT_W(FUNCT_W)) u_dec (
    .alu_op (alu_op),
    .funct  (funct),
    .ctrl   (ctrl)
  );

  alu2l_core #(.WIDTH(WIDTH)) u_core (
    .a        (op_a),
    .b        (op_b),
    .ctrl     (ctrl),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  assign ctrl_word = ctrl;

  always_comb begin
    if (zero)
      assert_zero_result_R9: assert (result == '0);
    if (ctrl_word == 4'b1100)
      assert_nor_value_R6: assert (result == ~(op_a | op_b));
  end

endmodule

// File: tb/alu_two_level_tb.sv
module alu_two_level_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [1:0]  alu_op = '0;
  logic [5:0]  funct = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic [3:0]  ctrl_word;
  logic [31:0] result;
  logic        zero, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_two_level u_dut (
    .alu_op(alu_op), .funct(funct), .op_a(op_a), .op_b(op_b),
    .ctrl_word(ctrl_word), .result(result), .zero(zero), .overflow(overflow)
  );

  function automatic logic [3:0] want_ctrl(input logic [1:0] op, input logic [5:0] f);
    if (op == 2'b00) return 4'b0010;
    if (op == 2'b01) return 4'b0110;
    case (f[3:0])
      4'b0000: return 4'b0010;
      4'b0010: return 4'b0110;
      4'b0100: return 4'b0000;
      4'b0101: return 4'b0001;
      4'b0111: return 4'b1100;
      4'b1010: return 4'b0111;
      default: return 4'b0010;
    endcase
  endfunction

  function automatic logic [31:0] corner(input int i);
    case (i)
      0: return 32'h0000_0000;  1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;  3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;  5: return 32'h8000_0001;
      6: return 32'h7FFF_FFFE;  7: return 32'hAAAA_5555;
      8: return 32'h5555_AAAA;  9: return 32'h0000_FFFF;
      default: return 32'h1234_5678;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (op=%b funct=%b a=%h b=%h)",
               tag, what, got, exp, alu_op, funct, op_a, op_b);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [5:0] f,
                       input logic [31:0] a, input logic [31:0] b);
    logic [3:0] cw;
    logic signed [32:0] wide;
    logic [31:0] er;
    logic eo;
    @(posedge clk);
    alu_op = op; funct = f; op_a = a; op_b = b;
    @(negedge clk);
    cw = want_ctrl(op, f);
    eo = 1'b0;
    case (cw)
      4'b0000: er = a & b;
      4'b0001: er = a | b;
      4'b1100: er = ~(a | b);
      4'b0010: begin wide = {a[31], a} + {b[31], b}; er = wide[31:0]; eo = wide[32] != wide[31]; end
      4'b0110: begin wide = {a[31], a} - {b[31], b}; er = wide[31:0]; eo = wide[32] != wide[31]; end
      default: er = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
    check(op[1] ? "R3" : (op[0] ? "R2" : "R1"), "ctrl_word", {28'd0, ctrl_word}, {28'd0, cw});
    if (cw == 4'b0111)      check("R8", "less-than", result, er);
    else if (cw[1:0] == 2'b10) check("R7", "sum", result, er);
    else                    check("R6", "logic", result, er);
    check("R9", "zero", {31'd0, zero}, {31'd0, (er == 32'd0)});
    check("R10", "overflow", {31'd0, overflow}, {31'd0, eo});
  endtask

  initial begin
    logic [31:0] lfsr;
    logic [5:0] fsel [6];
    fsel[0] = 6'b100000; fsel[1] = 6'b100010; fsel[2] = 6'b100100;
    fsel[3] = 6'b100101; fsel[4] = 6'b100111; fsel[5] = 6'b101010;

    // idle state: all-zero inputs give add of zeros
    @(negedge clk);
    check("R9", "idle zero", {31'd0, zero}, 32'd1);
    check("R7", "idle result", result, 32'd0);

    // R1 R2 R3 R4: full decode sweep of class code and function field
    for (int op = 0; op < 4; op++)
      for (int f = 0; f < 64; f++)
        apply(op[1:0], f[5:0], 32'h0000_0003, 32'h0000_0005);

    // R5: control word layout for each selection
    apply(2'b10, 6'b000111, 32'h0F0F_0F0F, 32'h00FF_00FF);
    check("R5", "nor word via bits 5..4 ignored", {28'd0, ctrl_word}, 32'hC);
    apply(2'b11, 6'b011010, 32'h8000_0000, 32'h0000_0001);
    check("R5", "less word under class 11", {28'd0, ctrl_word}, 32'h7);
    check("R8", "most negative below one", result, 32'd1);
    apply(2'b10, 6'b101111, 32'h1, 32'h2);
    check("R4", "unsupported defaults add", result, 32'd3);

    // operand corner cross product for every register function
    for (int s = 0; s < 6; s++)
      for (int i = 0; i < 11; i++)
        for (int j = 0; j < 11; j++)
          apply(2'b10, fsel[s], corner(i), corner(j));

    // class codes on corners: add for memory access, subtract for compare
    for (int i = 0; i < 11; i++)
      for (int j = 0; j < 11; j++) begin
        apply(2'b00, 6'b111111, corner(i), corner(j));
        apply(2'b01, 6'b100101, corner(i), corner(j));
      end

    // pseudo-random operands
    lfsr = 32'hACE1_2468;
    for (int n = 0; n < 300; n++) begin
      logic [31:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = (n % 7 == 0) ? ra : lfsr;
      apply(2'b10, fsel[n % 6], ra, rb);
    end

    // equal operands under subtract set zero
    apply(2'b01, 6'b000000, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    check("R9", "equal compare", {31'd0, zero}, 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule